// File: doc/BRIEF.md
# Byte-Wide Indirect Memory Access Port

This block gives a narrow I/O bus access to a byte memory that is too large to map directly. It has four byte registers, chosen by a 2-bit select. Two of them set the low and high halves of a 16-bit address pointer. A third is an unused slot. The fourth is a data window that reads or writes the memory byte the pointer selects. The memory itself sits outside the block and is reached through a single-port synchronous RAM interface.

After every data-window write the pointer returns to zero, so software must set the pointer again before the next write. Two lock inputs each guard a fixed 16-byte region of the memory. While a region's lock is set, writes to it are dropped and reads from it return all ones. Any address at or above the configured memory size behaves the same way, whatever the locks are. A read result appears on the data output in the cycle after the read strobe and stays there until the next read strobe.

Top module: `idx_nvram_port`

## Requirements
- R1: A write strobe with select 0 loads the write data into pointer bits 7:0 and leaves bits 15:8 unchanged.
- R2: A write strobe with select 1 loads the write data into pointer bits 15:8 and leaves bits 7:0 unchanged.
- R3: A write strobe with select 3 stores the write data at the pointed memory byte in the same cycle. The pointer is then 0x0000, and this holds even when the write itself was dropped.
- R4: A read strobe with select 3 fetches the pointed byte. The byte is on io_rdata_o from the cycle after the strobe until the next read strobe.
- R5: While lock_i[0] is 1, pointer values 0x20 to 0x2F reach no memory. Writes there are dropped and reads return 0xFF. Address 0x30 is not affected.
- R6: While lock_i[1] is 1, pointer values 0x30 to 0x3F reach no memory. Writes there are dropped and reads return 0xFF. Address 0x40 is not affected.
- R7: A pointer value at or above MEM_SIZE causes no memory access. Writes are dropped, without wrapping onto a lower address, and reads return 0xFF.
- R8: A read strobe with select 3 leaves the pointer unchanged, so repeated reads return the same byte.
- R9: A read strobe with select 0, 1 or 2 returns 0xFF. A write strobe with select 2 changes neither the pointer nor the memory.
- R10: Reset clears the pointer to 0x0000 and drives io_rdata_o to 0xFF until the first read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_en_i | input | 1 | Access strobe, one cycle per access |
| io_we_i | input | 1 | 1 = write, 0 = read |
| io_sel_i | input | 2 | Register select: 0 pointer low, 1 pointer high, 2 unused, 3 data window |
| io_wdata_i | input | 8 | Write data |
| io_rdata_o | output | 8 | Read data, valid the cycle after a read strobe |
| lock_i | input | NUM_LOCK | Region lock bits, bit g guards region g |
| mem_req_o | output | 1 | RAM access request |
| mem_we_o | output | 1 | RAM write enable |
| mem_addr_o | output | AW = clog2(MEM_SIZE) | RAM byte address |
| mem_wdata_o | output | 8 | RAM write data |
| mem_rdata_i | input | 8 | RAM read data, one cycle after the request |

## Verification
The bench builds the block with MEM_SIZE = 256 and the default lock regions at 0x20 and 0x30. With a memory that small, a pointer high byte of 0x01 lands just past the end of memory. The top byte 0xFF and the first out-of-range address 0x100 sit next to each other, so the bench can show that a dropped write does not wrap onto address 0. A 256-byte model also lets the bench keep a full expected copy of the memory, and every lock-region edge (0x1F, 0x20, 0x2F, 0x30, 0x3F, 0x40) falls inside it.

// File: rtl/nvr_pkg.sv
package nvr_pkg;
  localparam int DATA_W = 8;
  localparam int PTR_W  = 2 * DATA_W;
  localparam int EXT_W  = PTR_W + 1;

  typedef logic [EXT_W-1:0] ext_t;

  typedef enum logic [1:0] {
    PORT_ADDR_LO = 2'd0,
    PORT_ADDR_HI = 2'd1,
    PORT_SPARE   = 2'd2,
    PORT_DATA    = 2'd3
  } port_e;

  localparam logic [DATA_W-1:0] FILL_BYTE = '1;
endpackage

// File: rtl/nvr_addr_ptr.sv
module nvr_addr_ptr
  import nvr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_lo_i,
  input  logic              ld_hi_i,
  input  logic              clr_i,
  input  logic [DATA_W-1:0] byte_i,
  output logic [PTR_W-1:0]  ptr_o
);
  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (clr_i) begin
      ptr_q <= '0;
    end else begin
      if (ld_lo_i) ptr_q[DATA_W-1:0]     <= byte_i;
      if (ld_hi_i) ptr_q[PTR_W-1:DATA_W] <= byte_i;
    end
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/nvr_access_gate.sv
module nvr_access_gate
  import nvr_pkg::*;
#(
  parameter int                        MEM_SIZE   = 8192,
  parameter int                        NUM_LOCK   = 2,
  parameter int                        REGION_LEN = 16,
  parameter logic [NUM_LOCK*PTR_W-1:0] LOCK_BASES = {16'h0030, 16'h0020}
) (
  input  logic [PTR_W-1:0]    ptr_i,
  input  logic [NUM_LOCK-1:0] lock_i,
  output logic                allow_o
);
  localparam ext_t SIZE_X = ext_t'(MEM_SIZE);

  ext_t                ptr_x;
  logic [NUM_LOCK-1:0] blk;
  logic                in_range;

  assign ptr_x    = {1'b0, ptr_i};
  assign in_range = ptr_x < SIZE_X;

  for (genvar g = 0; g < NUM_LOCK; g++) begin : g_rgn
    localparam ext_t RGN_LO = {1'b0, LOCK_BASES[g*PTR_W +: PTR_W]};
    localparam ext_t RGN_HI = RGN_LO + ext_t'(REGION_LEN);
    assign blk[g] = lock_i[g] && (ptr_x >= RGN_LO) && (ptr_x < RGN_HI);
  end

  assign allow_o = in_range && !(|blk);
endmodule

// File: rtl/nvr_read_return.sv
module nvr_read_return
  import nvr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_stb_i,
  input  logic              hit_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic hit_q;

  // select RAM data only when the last read strobe actually reached memory
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       hit_q <= 1'b0;
    else if (rd_stb_i) hit_q <= hit_i;
  end

  assign rdata_o = hit_q ? mem_rdata_i : FILL_BYTE;
endmodule

// File: rtl/idx_nvram_port.sv
module idx_nvram_port
  import nvr_pkg::*;
#(
  parameter int                        MEM_SIZE   = 8192,
  parameter int                        NUM_LOCK   = 2,
  parameter int                        REGION_LEN = 16,
  parameter logic [NUM_LOCK*PTR_W-1:0] LOCK_BASES = {16'h0030, 16'h0020},
  localparam int                       AW = (MEM_SIZE > 1) ? $clog2(MEM_SIZE) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                io_en_i,
  input  logic                io_we_i,
  input  logic [1:0]          io_sel_i,
  input  logic [DATA_W-1:0]   io_wdata_i,
  output logic [DATA_W-1:0]   io_rdata_o,
  input  logic [NUM_LOCK-1:0] lock_i,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic [AW-1:0]       mem_addr_o,
  output logic [DATA_W-1:0]   mem_wdata_o,
  input  logic [DATA_W-1:0]   mem_rdata_i
);
  port_e            sel;
  logic             wr_stb, rd_stb;
  logic             ld_lo, ld_hi, data_wr, data_rd, spare_wr;
  logic             allow;
  logic [PTR_W-1:0] ptr;

  assign sel      = port_e'(io_sel_i);
  assign wr_stb   = io_en_i && io_we_i;
  assign rd_stb   = io_en_i && !io_we_i;
  assign ld_lo    = wr_stb && (sel == PORT_ADDR_LO);
  assign ld_hi    = wr_stb && (sel == PORT_ADDR_HI);
  assign spare_wr = wr_stb && (sel == PORT_SPARE);
  assign data_wr  = wr_stb && (sel == PORT_DATA);
  assign data_rd  = rd_stb && (sel == PORT_DATA);

  nvr_addr_ptr u_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ld_lo_i (ld_lo),
    .ld_hi_i (ld_hi),
    .clr_i   (data_wr),
    .byte_i  (io_wdata_i),
    .ptr_o   (ptr)
  );

  nvr_access_gate #(
    .MEM_SIZE   (MEM_SIZE),
    .NUM_LOCK   (NUM_LOCK),
    .REGION_LEN (REGION_LEN),
    .LOCK_BASES (LOCK_BASES)
  ) u_gate (
    .ptr_i   (ptr),
    .lock_i  (lock_i),
    .allow_o (allow)
  );

  assign mem_req_o   = (data_wr || data_rd) && allow;
  assign mem_we_o    = data_wr && allow;
  assign mem_addr_o  = ptr[AW-1:0];
  assign mem_wdata_o = io_wdata_i;

  nvr_read_return u_rret (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_stb_i    (rd_stb),
    .hit_i       (data_rd && allow),
    .mem_rdata_i (mem_rdata_i),
    .rdata_o     (io_rdata_o)
  );

  AST_LO_KEEPS_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_lo |=> (ptr[PTR_W-1:DATA_W] == $past(ptr[PTR_W-1:DATA_W])) &&
              (ptr[DATA_W-1:0] == $past(io_wdata_i))); // R1
  AST_HI_KEEPS_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_hi |=> (ptr[DATA_W-1:0] == $past(ptr[DATA_W-1:0])) &&
              (ptr[PTR_W-1:DATA_W] == $past(io_wdata_i))); // R2
  AST_PTR_CLR_AFTER_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_wr |=> (ptr == '0)); // R3
  AST_RD_KEEPS_PTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_rd |=> $stable(ptr)); // R8
  AST_SPARE_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spare_wr |=> $stable(ptr)); // R9
  AST_OOR_NO_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (int'(ptr) < MEM_SIZE)); // R7
  AST_BLOCKED_RD_FF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stb && !mem_req_o) |=> (io_rdata_o == FILL_BYTE)); // R9
  AST_WE_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_req_o && io_we_i)); // R3

  for (genvar g = 0; g < NUM_LOCK; g++) begin : g_lock_chk
    localparam int RB = int'(LOCK_BASES[g*PTR_W +: PTR_W]);
    AST_LOCKED_NO_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lock_i[g] && (int'(ptr) >= RB) && (int'(ptr) < RB + REGION_LEN)) |-> !mem_req_o); // R5, R6
  end
endmodule

// File: tb/idx_nvram_port_test.sv
`timescale 1ns/1ps
module idx_nvram_port_test;
  localparam int MEM_SIZE = 256;
  localparam int AW       = 8;
  localparam int N_VEC    = 26;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       io_en = 1'b0, io_we = 1'b0;
  logic [1:0] io_sel = '0;
  logic [7:0] io_wdata = '0;
  logic [7:0] io_rdata;
  logic [1:0] lock = '0;
  logic       mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [7:0] ram_q;
  logic [7:0] ram [MEM_SIZE];

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #2 clk = ~clk;

  idx_nvram_port #(.MEM_SIZE(MEM_SIZE)) uut (
    .clk_i(clk), .rst_ni(rst_n), .io_en_i(io_en), .io_we_i(io_we),
    .io_sel_i(io_sel), .io_wdata_i(io_wdata), .io_rdata_o(io_rdata),
    .lock_i(lock), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(ram_q)
  );

  // synchronous RAM model
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) ram[mem_addr] <= mem_wdata;
      else        ram_q <= ram[mem_addr];
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < 20000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // {write, sel[1:0], data[7:0], expected[7:0]}
  localparam logic [18:0] VEC [N_VEC] = '{
    {1'b1, 2'd0, 8'h10, 8'h00},  // ptr low
    {1'b1, 2'd1, 8'h00, 8'h00},  // ptr high
    {1'b1, 2'd3, 8'h5A, 8'h00},  // store 0x10, ptr clears (R3)
    {1'b1, 2'd0, 8'h10, 8'h00},
    {1'b0, 2'd3, 8'h00, 8'h5A},  // read back (R4)
    {1'b0, 2'd3, 8'h00, 8'h5A},  // ptr kept on read (R8)
    {1'b1, 2'd0, 8'hFF, 8'h00},
    {1'b1, 2'd3, 8'hC3, 8'h00},  // top byte
    {1'b1, 2'd0, 8'hFF, 8'h00},
    {1'b1, 2'd1, 8'h00, 8'h00},
    {1'b0, 2'd3, 8'h00, 8'hC3},
    {1'b1, 2'd1, 8'h01, 8'h00},  // ptr 0x01FF, low kept (R2)
    {1'b0, 2'd3, 8'h00, 8'hFF},  // out of range (R7)
    {1'b1, 2'd0, 8'h00, 8'h00},  // ptr 0x0100, high kept (R1)
    {1'b0, 2'd3, 8'h00, 8'hFF},
    {1'b1, 2'd3, 8'h77, 8'h00},  // dropped, ptr clears (R7, R3)
    {1'b0, 2'd3, 8'h00, 8'h3C},  // mem[0] untouched, no wrap
    {1'b1, 2'd0, 8'h10, 8'h00},
    {1'b1, 2'd2, 8'h33, 8'h00},  // spare write ignored (R9)
    {1'b0, 2'd3, 8'h00, 8'h5A},
    {1'b0, 2'd0, 8'h00, 8'hFF},  // R9
    {1'b0, 2'd1, 8'h00, 8'hFF},
    {1'b0, 2'd2, 8'h00, 8'hFF},
    {1'b1, 2'd0, 8'h01, 8'h00},
    {1'b1, 2'd3, 8'hEE, 8'h00},
    {1'b0, 2'd3, 8'h00, 8'h3C}   // ptr cleared: mem[0]
  };

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic io_wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    io_en = 1'b1; io_we = 1'b1; io_sel = s; io_wdata = d;
    @(negedge clk);
    io_en = 1'b0; io_we = 1'b0;
  endtask

  task automatic io_rd(input logic [1:0] s, output logic [7:0] d);
    @(negedge clk);
    io_en = 1'b1; io_we = 1'b0; io_sel = s;
    @(negedge clk);
    io_en = 1'b0;
    d = io_rdata;
  endtask

  task automatic set_ptr(input logic [15:0] a);
    io_wr(2'd0, a[7:0]);
    io_wr(2'd1, a[15:8]);
  endtask

  task automatic rd_at(input logic [15:0] a, input string tag, input logic [7:0] exp);
    logic [7:0] d;
    set_ptr(a);
    io_rd(2'd3, d);
    chk(tag, d, exp);
  endtask

  task automatic wr_at(input logic [15:0] a, input logic [7:0] v);
    set_ptr(a);
    io_wr(2'd3, v);
  endtask

  initial begin
    logic [7:0] d;
    for (int i = 0; i < MEM_SIZE; i++) ram[i] = 8'(i) ^ 8'h3C;
    ram_q = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 rdata after reset", io_rdata, 8'hFF);
    io_rd(2'd3, d);
    chk("R10 ptr zero after reset", d, 8'h3C);

    for (int i = 0; i < N_VEC; i++) begin
      if (VEC[i][18]) io_wr(VEC[i][17:16], VEC[i][15:8]);
      else begin
        io_rd(VEC[i][17:16], d);
        chk($sformatf("R4 R7 R9 table step %0d", i), d, VEC[i][7:0]);
      end
    end

    // reset mid-run clears the pointer
    set_ptr(16'h0010);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk("R10 rdata after second reset", io_rdata, 8'hFF);
    io_rd(2'd3, d);
    chk("R10 ptr cleared by reset", d, 8'h3C);

    // lock regions
    wr_at(16'h0025, 8'h11);
    wr_at(16'h0035, 8'h22);
    lock = 2'b01;
    wr_at(16'h0025, 8'h99);
    rd_at(16'h0025, "R5 locked read", 8'hFF);
    rd_at(16'h0020, "R5 low edge", 8'hFF);
    rd_at(16'h002F, "R5 high edge", 8'hFF);
    rd_at(16'h001F, "R5 below region", 8'h1F ^ 8'h3C);
    rd_at(16'h0030, "R5 next region open", 8'h30 ^ 8'h3C);
    rd_at(16'h0035, "R5 other region", 8'h22);
    io_rd(2'd3, d);
    chk("R8 read keeps ptr", d, 8'h22);
    set_ptr(16'h0026);
    io_wr(2'd3, 8'h44);
    io_rd(2'd3, d);
    chk("R3 ptr clears after locked write", d, 8'h3C);
    lock = 2'b00;
    rd_at(16'h0025, "R5 unlocked, write dropped", 8'h11);
    rd_at(16'h0026, "R5 unlocked, second drop", 8'h26 ^ 8'h3C);

    lock = 2'b10;
    wr_at(16'h0035, 8'h98);
    rd_at(16'h0035, "R6 locked read", 8'hFF);
    rd_at(16'h0030, "R6 low edge", 8'hFF);
    rd_at(16'h003F, "R6 high edge", 8'hFF);
    rd_at(16'h0040, "R6 above region", 8'h40 ^ 8'h3C);
    rd_at(16'h0025, "R6 other region", 8'h11);
    lock = 2'b00;
    rd_at(16'h0035, "R6 unlocked, write dropped", 8'h22);

    lock = 2'b11;
    rd_at(16'h0100, "R7 out of range with locks", 8'hFF);
    lock = 2'b00;
    wr_at(16'h0080, 8'hA1);
    rd_at(16'h0080, "R3 store and fetch", 8'hA1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule